// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the synchronized transmit-data line coming from the host and the enable of the bus low-side driver. A low level on the transmit line normally pulls the bus dominant. A high level, or an undriven line held high by its pull-up, leaves the bus recessive. The block stops a transmit line that is stuck low from holding the bus dominant forever. After a continuous low that lasts longer than a timeout, the driver is forced recessive and a status flag is raised. The lockout ends only after the transmit line has stayed high for longer than a release time. A single rising edge is not enough to end it.

The mode controller supplies a transmit-enable signal. The driver can be active only while this signal is high, which corresponds to Normal mode. The raw transmit level is passed to the mode controller without change, even during a lockout. A line that is shorted low can therefore still select the sleep path when the mode-select input falls. The timeout and release times are given as parameters in clock cycles. The analog slope control of the driver is outside this block.

Top module: `txd_dom_guard`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, timeout_o is 0. With txd_i high, drv_on_o is 0.
- R2: drv_on_o is 1 exactly when tx_en_i is 1, txd_i is 0 (0 = dominant request) and no lockout is active. drv_on_o is 0 whenever txd_i is 1.
- R3: While tx_en_i is 0, drv_on_o stays 0 whatever the level of txd_i.
- R4: If txd_i is sampled low on TIMEOUT_CYC consecutive clock edges, the driver stays on. On the next consecutive low sample (edge TIMEOUT_CYC+1), timeout_o goes to 1 and drv_on_o goes to 0 in the same cycle.
- R5: Any single high sample of txd_i restarts the low-time count. Low runs of TIMEOUT_CYC cycles that are separated by one high cycle never cause a lockout.
- R6: While timeout_o is 1, drv_on_o stays 0 even with txd_i low and tx_en_i high. A continued low keeps timeout_o at 1.
- R7: A lockout ends at the clock edge of the (RELEASE_CYC+1)-th consecutive high sample of txd_i. At that edge timeout_o returns to 0. A high run of RELEASE_CYC cycles or fewer, followed by a low sample, leaves the lockout in place, and the high count starts again from zero.
- R8: txd_mode_o always equals txd_i, including during a lockout.
- R9: The low-time count runs on the raw txd_i level whatever tx_en_i is. A lockout that builds up while tx_en_i is 0 is flagged and is released in the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | 1 | Synchronized transmit data, 0 requests dominant |
| tx_en_i | input | 1 | Transmit enable from the mode controller (Normal mode) |
| drv_on_o | output | 1 | Low-side driver on; 1 pulls the bus dominant |
| timeout_o | output | 1 | Dominant-timeout lockout active |
| txd_mode_o | output | 1 | Raw transmit level passed on to the mode controller |

## Verification
The first pattern is a short alternating bit pattern with transmit enabled. It shows that the driver follows the data when no lockout is possible. Low runs exactly at the timeout, split by single high cycles, separate a counter that restarts on any high sample from one that only decays. A run one cycle longer pins down the exact cycle of lockout entry. In the lockout, a high pulse of exactly the release length followed by a low shows that a bare rising edge cannot clear it, while a pulse one cycle longer clears it at a known edge. A stuck low with transmit disabled confirms that the timer watches the raw level and that the mode-select path sees that level throughout.

// File: rtl/txd_dom_guard_pkg.sv
package txd_dom_guard_pkg;
  typedef enum logic {
    GUARD_ACTIVE = 1'b0,
    GUARD_LOCKED = 1'b1
  } guard_state_e;
endpackage

// File: rtl/txd_run_counter.sv
// Counts consecutive cycles with hit_i set; exceed_o flags the sample past LIMIT.
module txd_run_counter #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic exceed_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!hit_i)      cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign exceed_o = hit_i && (cnt_q == LIM);
endmodule

// File: rtl/txd_lock_fsm.sv
module txd_lock_fsm
  import txd_dom_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_exceed_i,
  input  logic high_exceed_i,
  output logic locked_o
);
  guard_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GUARD_ACTIVE: if (low_exceed_i)  state_d = GUARD_LOCKED;
      GUARD_LOCKED: if (high_exceed_i) state_d = GUARD_ACTIVE;
      default:                         state_d = GUARD_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= GUARD_ACTIVE;
    else         state_q <= state_d;
  end

  assign locked_o = (state_q == GUARD_LOCKED);
endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
  parameter int unsigned TIMEOUT_CYC = 2000,
  parameter int unsigned RELEASE_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic tx_en_i,
  output logic drv_on_o,
  output logic timeout_o,
  output logic txd_mode_o
);
  logic low_exceed, high_exceed, locked;

  txd_run_counter #(.LIMIT(TIMEOUT_CYC)) u_low_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (~txd_i),
    .exceed_o (low_exceed)
  );

  txd_run_counter #(.LIMIT(RELEASE_CYC)) u_high_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (txd_i),
    .exceed_o (high_exceed)
  );

  txd_lock_fsm u_lock (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .low_exceed_i  (low_exceed),
    .high_exceed_i (high_exceed),
    .locked_o      (locked)
  );

  assign drv_on_o   = tx_en_i & ~txd_i & ~locked;
  assign timeout_o  = locked;
  // raw level: a shorted-low line must still reach the sleep decision
  assign txd_mode_o = txd_i;
endmodule

// File: rtl/txd_dom_guard_chk.sv
module txd_dom_guard_chk #(
  parameter int unsigned TIMEOUT_CYC = 2000,
  parameter int unsigned RELEASE_CYC = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic txd_i,
  input logic tx_en_i,
  input logic drv_on_o,
  input logic timeout_o,
  input logic txd_mode_o
);
  localparam int unsigned LW = $clog2(TIMEOUT_CYC + 2);
  localparam int unsigned HW = $clog2(RELEASE_CYC + 2);
  localparam logic [LW-1:0] LO_TOP = LW'(TIMEOUT_CYC + 1);
  localparam logic [HW-1:0] HI_TOP = HW'(RELEASE_CYC + 1);

  logic [LW-1:0] lo_run;
  logic [HW-1:0] hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run <= '0;
      hi_run <= '0;
    end else begin
      lo_run <= txd_i ? '0 : ((lo_run == LO_TOP) ? lo_run : lo_run + 1'b1);
      hi_run <= !txd_i ? '0 : ((hi_run == HI_TOP) ? hi_run : hi_run + 1'b1);
    end
  end

  AST_HIGH_RECESSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_i |-> !drv_on_o); // R2
  AST_EN_GATES_DRV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> !drv_on_o); // R3
  AST_LOCK_ENTRY_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (lo_run == LO_TOP)); // R4
  AST_LOCK_MUTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !drv_on_o); // R6
  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !txd_i) |=> timeout_o); // R6
  AST_RELEASE_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(timeout_o) |-> (hi_run == HI_TOP)); // R7
  AST_MODE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(txd_i) |-> $changed(txd_mode_o)); // R8
endmodule

bind txd_dom_guard txd_dom_guard_chk #(
  .TIMEOUT_CYC (TIMEOUT_CYC),
  .RELEASE_CYC (RELEASE_CYC)
) u_chk (.*);

// File: tb/txd_dom_guard_bench.sv
`timescale 1ns/1ps
module txd_dom_guard_bench;
  localparam int T = 20;
  localparam int R = 5;

  typedef struct {
    logic  drv;
    logic  to;
    logic  mode;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1;
  logic tx_en = 1'b0;
  logic drv_on, tmo, txd_mode;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  exp_t q[$];
  int lo_run = 0;
  int hi_run = 0;
  bit m_lock = 0;

  always #2 clk = ~clk;

  txd_dom_guard #(.TIMEOUT_CYC(T), .RELEASE_CYC(R)) u_txd_dom_guard (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .txd_i      (txd),
    .tx_en_i    (tx_en),
    .drv_on_o   (drv_on),
    .timeout_o  (tmo),
    .txd_mode_o (txd_mode)
  );

  task automatic check1(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // driver: apply one sample, push the expected outputs, then update the reference
  task automatic step(input logic t, input logic en, input string tag);
    exp_t it;
    @(negedge clk);
    txd = t;
    tx_en = en;
    #0.5;
    it.drv  = en & ~t & ~m_lock;
    it.to   = m_lock;
    it.mode = t;
    it.tag  = tag;
    q.push_back(it);
    if (t) begin hi_run++; lo_run = 0; end
    else   begin lo_run++; hi_run = 0; end
    if (!m_lock && lo_run > T)     m_lock = 1;
    else if (m_lock && hi_run > R) m_lock = 0;
  endtask

  task automatic hold(input logic t, input logic en, input int n, input string tag);
    for (int i = 0; i < n; i++) step(t, en, tag);
  endtask

  // monitor: pop and compare once per cycle
  always @(negedge clk) begin
    exp_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (drv_on !== it.drv || tmo !== it.to || txd_mode !== it.mode) begin
        bad++;
        $display("FAIL %s actual drv=%b to=%b mode=%b expected drv=%b to=%b mode=%b",
                 it.tag, drv_on, tmo, txd_mode, it.drv, it.to, it.mode);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check1("R1", tmo, 1'b0, "timeout in reset");
    check1("R1", drv_on, 1'b0, "drv in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check1("R1", tmo, 1'b0, "timeout after reset");
    check1("R1", drv_on, 1'b0, "drv after reset");

    // R2: plain data pattern with transmit enabled
    step(0, 1, "R2"); step(1, 1, "R2"); step(0, 1, "R2"); step(0, 1, "R2");
    step(1, 1, "R2"); step(1, 1, "R2"); step(0, 1, "R2"); step(1, 1, "R2");
    // R3: transmit disabled, short lows
    hold(0, 0, 6, "R3");
    hold(1, 0, 2, "R3");
    // R5: low runs of exactly T split by single highs
    for (int k = 0; k < 4; k++) begin
      hold(0, 1, T, "R5");
      step(1, 1, "R5");
    end
    hold(1, 1, 2, "R5");
    // R4 and R6: stuck low one run past the limit and beyond
    hold(0, 1, T + 1, "R4");
    hold(0, 1, 8, "R6");
    // R7 with R8: high pulse of exactly R does not release
    hold(1, 1, R, "R7");
    hold(0, 1, 3, "R8");
    hold(1, 1, R - 1, "R7");
    step(0, 1, "R8");
    // R7: R+1 highs release, then dominant works again
    hold(1, 1, R + 1, "R7");
    hold(1, 1, 2, "R7");
    hold(0, 1, 3, "R2");
    step(1, 1, "R2");
    // R9: stuck low with transmit disabled still locks and releases
    hold(0, 0, T + 4, "R9");
    step(0, 1, "R9");
    hold(1, 1, R + 3, "R9");
    step(0, 1, "R9");
    step(1, 1, "R9");

    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule